// File: doc/BRIEF.md
# Chained Lookahead Add/Subtract Unit

This block is a purely combinational 16-bit adder-subtractor built from two identical 8-bit lookahead slices. Each slice forms per-bit generate, propagate and half-sum terms from its operand bits and runs them through a carry chain. The slice exposes carry-in and carry-out so that the slices can be joined end to end. One mode input picks addition or subtraction. In subtract mode every slice complements its B bits. The carry into the lowest slice is the external carry/borrow input XORed with the mode bit. That XOR supplies the +1 of the two's complement and also turns an active-high borrow into the active-low carry the adder expects.

The carry-out of the low slice drives the carry-in of the high slice with no further gating. The final carry-out is therefore a true carry when adding and a "no borrow" flag when subtracting. In four-state simulation, an unknown mode input drives the whole result to unknown so that a bad control shows up at once.

Top module: `adsub_cascade`

## Requirements
- R1: With `sub_mode` = 0, `result` equals (opa + opb + cbin) mod 65536 and `cout` is bit 16 of that sum.
- R2: With `sub_mode` = 1, `result` equals (opa - opb - cbin) mod 65536, where `cbin` = 1 means one extra unit is borrowed.
- R3: With `sub_mode` = 1, `cout` is 1 exactly when opa >= opb + cbin (no borrow out), and 0 otherwise.
- R4: In add mode a carry out of bit 7 reaches bit 8: 0x00FF + 0x0001 gives 0x0100 with `cout` 0.
- R5: In subtract mode a borrow crosses the boundary between bits 7 and 8: 300 - 50 gives 0x00FA, 350 - 50 gives 0x012C, and 50 - 250 gives 0xFF38 with `cout` 0.
- R6: At the operand extremes, 0xFFFF + 0xFFFF with `cbin` 1 gives 0xFFFF with `cout` 1. In subtract mode, 0x0000 - 0x0000 with `cbin` 1 gives 0xFFFF with `cout` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 16 | First operand (minuend in subtract mode) |
| opb | input | 16 | Second operand (subtrahend in subtract mode) |
| sub_mode | input | 1 | 0 selects add, 1 selects subtract |
| cbin | input | 1 | Carry-in when adding; active-high borrow-in when subtracting |
| result | output | 16 | Sum or difference, modulo 2^16 |
| cout | output | 1 | Carry-out when adding; 1 means no borrow when subtracting |

## Verification
Fixed vectors aim at the slice seam. Some make a carry or borrow cross from bit 7 into bit 8 and some keep it inside a slice. Any fault in the link between the slices or in the low carry-in shows up in the upper byte. The cases at the all-ones and all-zero extremes, run with the carry/borrow input both set and clear, separate a wrong carry-in polarity from a wrong carry-out meaning. Random operands in both modes, with a random carry/borrow input, are then compared against a behavioural sum or difference. These cases catch errors in generate, propagate or half-sum at any bit position.

// File: rtl/adsub_pkg.sv
`timescale 1ns/1ps
package adsub_pkg;

    parameter int ADS_SLICE_W    = 8;
    parameter int ADS_NUM_SLICES = 2;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_mode_e;

    // per-bit lookahead terms
    typedef struct packed {
        logic gen;
        logic prop;
        logic half;
    } bit_terms_t;

    function automatic bit_terms_t form_terms(input logic a_bit,
                                              input logic b_bit,
                                              input logic flip);
        bit_terms_t t;
        logic       b_eff;
        b_eff  = b_bit ^ flip;
        t.gen  = a_bit & b_eff;
        t.prop = a_bit | b_eff;
        t.half = a_bit ^ b_eff;
        return t;
    endfunction

endpackage

// File: rtl/pg_cell.sv
`timescale 1ns/1ps
module pg_cell
    import adsub_pkg::*;
(
    input  logic       a_bit,
    input  logic       b_bit,
    input  logic       flip,
    output bit_terms_t terms
);

    assign terms = form_terms(a_bit, b_bit, flip);

endmodule

// File: rtl/cla_slice.sv
`timescale 1ns/1ps
module cla_slice
    import adsub_pkg::*;
#(
    parameter int W = ADS_SLICE_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         invert_b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    bit_terms_t       terms [W];
    logic [W:0]       carry;

    assign carry[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        pg_cell u_cell (
            .a_bit (a[i]),
            .b_bit (b[i]),
            .flip  (invert_b),
            .terms (terms[i])
        );
        assign carry[i+1] = terms[i].gen | (terms[i].prop & carry[i]);
        assign sum[i]     = terms[i].half ^ carry[i];
    end

    assign cout = carry[W];

    // slice arithmetic cross-check against a plain add of the effective operand
    logic [W-1:0] b_view;
    assign b_view = b ^ {W{invert_b}};

    always_comb begin
        if (!$isunknown({a, b, invert_b, cin})) begin
            AST_SLICE_ARITH: assert ({cout, sum} ==
                ({1'b0, a} + {1'b0, b_view} + {{W{1'b0}}, cin})); // R1
        end
    end

endmodule

// File: rtl/adsub_cascade.sv
`timescale 1ns/1ps
module adsub_cascade
    import adsub_pkg::*;
#(
    parameter int SLICE_W    = ADS_SLICE_W,
    parameter int NUM_SLICES = ADS_NUM_SLICES
) (
    input  logic [SLICE_W*NUM_SLICES-1:0] opa,
    input  logic [SLICE_W*NUM_SLICES-1:0] opb,
    input  logic                          sub_mode,
    input  logic                          cbin,
    output logic [SLICE_W*NUM_SLICES-1:0] result,
    output logic                          cout
);

    localparam int TW = SLICE_W * NUM_SLICES;

    op_mode_e          mode;
    logic [NUM_SLICES:0] chain;
    logic [TW-1:0]     raw_sum;

    assign mode     = op_mode_e'(sub_mode);
    // borrow is active high at the port; the adder wants an active-low one
    assign chain[0] = cbin ^ (mode == OP_SUB);

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        cla_slice #(.W(SLICE_W)) u_slice (
            .a        (opa[s*SLICE_W +: SLICE_W]),
            .b        (opb[s*SLICE_W +: SLICE_W]),
            .invert_b (mode == OP_SUB),
            .cin      (chain[s]),
            .sum      (raw_sum[s*SLICE_W +: SLICE_W]),
            .cout     (chain[s+1])
        );
    end

    always_comb begin
        if ($isunknown(sub_mode))
            result = 'x;
        else
            result = raw_sum;
    end

    assign cout = chain[NUM_SLICES];

    always_comb begin
        if (!$isunknown({opa, opb, sub_mode, cbin})) begin
            if (sub_mode == 1'b0) begin
                AST_ADD_SUM: assert ({cout, result} ==
                    ({1'b0, opa} + {1'b0, opb} + {{TW{1'b0}}, cbin})); // R1
                AST_LOW_CARRY_ADD: assert (chain[1] ==
                    ((({1'b0, opa[SLICE_W-1:0]} + {1'b0, opb[SLICE_W-1:0]}
                      + {{SLICE_W{1'b0}}, cbin}) >> SLICE_W) != '0)); // R4
            end else begin
                AST_SUB_DIFF: assert (result ==
                    (opa - opb - {{(TW-1){1'b0}}, cbin})); // R2
                AST_SUB_NOBORROW: assert (cout ==
                    ({1'b0, opa} >= ({1'b0, opb} + {{TW{1'b0}}, cbin}))); // R3
                AST_LOW_NOBORROW: assert (chain[1] ==
                    ({1'b0, opa[SLICE_W-1:0]} >=
                     ({1'b0, opb[SLICE_W-1:0]} + {{SLICE_W{1'b0}}, cbin}))); // R5
            end
        end
    end

endmodule

// File: tb/sim_adsub_cascade.sv
`timescale 1ns/1ps
module sim_adsub_cascade;

    typedef struct {
        logic [15:0] res;
        logic        co;
        logic [15:0] a;
        logic [15:0] b;
        logic        m;
        logic        c;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] opa = '0;
    logic [15:0] opb = '0;
    logic        sub_mode = 1'b0;
    logic        cbin = 1'b0;
    logic [15:0] result;
    logic        cout;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    exp_t q[$];

    always #2 clk = ~clk;

    adsub_cascade u0 (
        .opa      (opa),
        .opb      (opb),
        .sub_mode (sub_mode),
        .cbin     (cbin),
        .result   (result),
        .cout     (cout)
    );

    task automatic drive(input logic [15:0] a, input logic [15:0] b,
                         input logic m, input logic c, input string tag);
        exp_t e;
        logic [16:0] s;
        @(posedge clk);
        #1;
        opa = a; opb = b; sub_mode = m; cbin = c;
        if (!m) begin
            s    = {1'b0, a} + {1'b0, b} + {16'd0, c};
            e.res = s[15:0];
            e.co  = s[16];
        end else begin
            e.res = a - b - {15'd0, c};
            e.co  = ({1'b0, a} >= ({1'b0, b} + {16'd0, c}));
        end
        e.a = a; e.b = b; e.m = m; e.c = c; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compares mid-cycle, well away from the rising edge
    always @(negedge clk) begin
        if (!rst && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (result !== e.res || cout !== e.co) begin
                fails++;
                $display("FAIL %s a=%h b=%h m=%b c=%b got=%h/%b exp=%h/%b",
                         e.tag, e.a, e.b, e.m, e.c, result, cout, e.res, e.co);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        drive(16'h0000, 16'h0000, 1'b0, 1'b0, "R1 zero");
        drive(16'd1234, 16'd4321, 1'b0, 1'b1, "R1 add cin");
        drive(16'h8000, 16'h8000, 1'b0, 1'b0, "R1 top carry");
        drive(16'h00FF, 16'h0001, 1'b0, 1'b0, "R4 seam carry");
        drive(16'h00FE, 16'h0001, 1'b0, 1'b1, "R4 seam via cin");
        drive(16'h007F, 16'h0001, 1'b0, 1'b0, "R4 no seam carry");
        drive(16'd300, 16'd50, 1'b1, 1'b0, "R5 300-50");
        drive(16'd350, 16'd50, 1'b1, 1'b0, "R5 350-50");
        drive(16'd50, 16'd250, 1'b1, 1'b0, "R5 50-250");
        drive(16'd100, 16'd40, 1'b1, 1'b1, "R2 borrow in");
        drive(16'd40, 16'd40, 1'b1, 1'b0, "R3 equal no borrow");
        drive(16'd40, 16'd40, 1'b1, 1'b1, "R3 equal with borrow");
        drive(16'hFFFF, 16'hFFFF, 1'b0, 1'b1, "R6 max add");
        drive(16'h0000, 16'h0000, 1'b1, 1'b1, "R6 zero sub borrow");
        drive(16'hFFFF, 16'h0000, 1'b1, 1'b0, "R6 max minus zero");
        for (int i = 0; i < 400; i++) begin
            logic m;
            m = i[0];
            drive(16'($urandom), 16'($urandom), m, 1'($urandom),
                  m ? "R2,R3 random" : "R1 random");
        end
        wait (q.size() == 0);
        @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

endmodule